// File: doc/BRIEF.md
# Pin Port Controller with Atomic Output Update

This block controls one port of up to sixteen pins. A 32-bit register bus with per-byte enables programs each pin. The fields are a 2-bit mode, an output type, a 2-bit drive speed, a 2-bit pull selection and a 4-bit alternate-function selector. From these fields the block derives the pad-side controls for every pin: output value, output enable, pull-up and pull-down requests, and the speed code. The output value comes either from the output data register or from one of sixteen peripheral outputs, depending on the pin's mode. The pad input is steered to the same selected peripheral channel.

Software can change output bits without a read-modify-write. A 32-bit set/clear register changes several bits in one bus write, and a set request beats a clear request on the same pin. A second register clears bits only. The pad levels are sampled into an input register on every clock.

Word offsets: 0x00 mode, 0x04 output type, 0x08 speed, 0x0C pull, 0x10 input data, 0x14 output data, 0x18 set/clear, 0x20 selector pins 0-7, 0x24 selector pins 8-15, 0x28 clear-only. Pin p occupies bits [2p+1:2p] in the 2-bit field registers and bit p in the 1-bit registers. Its selector is bits [4(p%8)+3:4(p%8)] of the low or high selector register.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset every mode field is 11 (analog), so the mode register reads 0xFFFFFFFF. Output type, speed, pull, output data and both selector registers read 0.
- R2: A write updates only the bytes whose enable bit is set. Output type and output data read 0 in bits 31:16. A write to the input data register has no effect, and so does any access whose address bits 1:0 are not 00. A read returns 0 when no read is requested.
- R3: In a set/clear write, a 1 in bit p (p < 16) sets output bit p and a 1 in bit 16+p clears it. Zero bits, and bytes whose enable bit is low, leave the output unchanged.
- R4: When bit p and bit 16+p are both 1 in the same set/clear write, output bit p becomes 1.
- R5: In a clear-only write (0x28), a 1 in bit p clears output bit p. Bits 31:16 are ignored.
- R6: The set/clear and clear-only registers always read 0.
- R7: The input data register holds the pad level of the previous clock edge. A pin in analog mode reads 0 there, and bits 31:16 read 0.
- R8: In mode 01 the pad output follows the output data bit. With output type 0 (push-pull) the output enable is 1.
- R9: With output type 1 (open-drain) in mode 01 or 10, a low source value gives enable 1 and output 0. A high source value gives enable 0.
- R10: In mode 10 the pad output source is peripheral output af_out_i[16p+s], where s is the pin's 4-bit selector.
- R11: af_in_o[16p+s] carries pad input p when pin p is not in analog mode. Every other channel of the pin is 0.
- R12: Pull field 01 requests pull-up and 10 requests pull-down; 00 and 11 request neither. Analog mode forces both pull requests low. Modes 00 and 11 hold the output enable low.
- R13: pad_speed_o always equals the speed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (6) | Byte address of the register |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, same cycle |
| pad_in_i | input | NPINS (16) | Pad input levels |
| pad_out_o | output | NPINS (16) | Pad output values |
| pad_oe_o | output | NPINS (16) | Pad output enables |
| pad_pu_o | output | NPINS (16) | Pull-up requests |
| pad_pd_o | output | NPINS (16) | Pull-down requests |
| pad_speed_o | output | 2*NPINS (32) | Per-pin speed codes |
| af_out_i | input | NPINS*16 (256) | Peripheral outputs, 16 per pin |
| af_in_o | output | NPINS*16 (256) | Peripheral inputs, 16 per pin |

## Verification
The assertions check on every cycle the rules that hold at any time. Set wins over clear, requested clears take effect, and the output register holds when it is not written. An open-drain pin never drives high, and input or analog pins never drive. Analog pins have no pull request and read 0 in the input register. Each pin carries at most one active peripheral input, and the write-only registers read 0. Other behaviours show only in the bench's scenarios, where a behavioural model is compared on every clock: byte-lane merging, the ignored writes, the one-cycle latency of input sampling, and selector routing of the sixteen peripheral channels.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  localparam int NAF      = 16;
  localparam int AF_SEL_W = 4;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_GPOUT  = 2'b01,
    PM_ALTFN  = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  // word index = byte offset / 4
  localparam int REG_MODE    = 0;
  localparam int REG_OTYPE   = 1;
  localparam int REG_SPEED   = 2;
  localparam int REG_PULL    = 3;
  localparam int REG_IDATA   = 4;
  localparam int REG_ODATA   = 5;
  localparam int REG_SETCLR  = 6;
  localparam int REG_AFLO    = 8;
  localparam int REG_AFHI    = 9;
  localparam int REG_CLRONLY = 10;

  // config register file slots
  localparam int CFG_MODE  = 0;
  localparam int CFG_OTYPE = 1;
  localparam int CFG_SPEED = 2;
  localparam int CFG_PULL  = 3;
  localparam int CFG_AFLO  = 4;
  localparam int CFG_AFHI  = 5;
  localparam int CFG_N     = 6;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_bits(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [31:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pin_pkg::*;
#(
  parameter int          NPINS    = 16,
  parameter logic [31:0] MODE_RST = 32'hFFFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_N-1:0]  wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       wmask_i,
  output logic [31:0]       cfg_o [CFG_N]
);

  localparam int F2_W  = 2*NPINS;
  localparam int AFB_W = AF_SEL_W*NPINS;
  localparam logic [31:0] M1  = (NPINS >= 32) ? 32'hFFFF_FFFF : ((32'h1 << NPINS) - 32'h1);
  localparam logic [31:0] M2  = (F2_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << F2_W) - 32'h1);
  localparam logic [31:0] MLO = (AFB_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << AFB_W) - 32'h1);
  localparam logic [31:0] MHI = (AFB_W <= 32) ? 32'h0 :
                                (AFB_W >= 64) ? 32'hFFFF_FFFF : ((32'h1 << (AFB_W-32)) - 32'h1);

  function automatic logic [31:0] valid_mask(input int k);
    case (k)
      CFG_OTYPE: return M1;
      CFG_AFLO:  return MLO;
      CFG_AFHI:  return MHI;
      default:   return M2;
    endcase
  endfunction

  for (genvar k = 0; k < CFG_N; k++) begin : g_reg
    localparam logic [31:0] VM = valid_mask(k);
    localparam logic [31:0] RV = (k == CFG_MODE) ? (MODE_RST & VM) : 32'h0;
    logic [31:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= RV;
      else if (wr_i[k]) q <= merge_bits(q, wdata_i, wmask_i & VM);
    end

    assign cfg_o[k] = q;
  end

endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data
  import gpio_pin_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_odr_i,
  input  logic             wr_setclr_i,
  input  logic             wr_clr_i,
  input  logic [31:0]      wdata_i,
  input  logic [31:0]      wmask_i,
  output logic [NPINS-1:0] odr_o
);

  logic [31:0]      eff;
  logic [NPINS-1:0] set_v, clr_v, base_v, odr_q;

  assign eff = wdata_i & wmask_i;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (wr_setclr_i) begin
      set_v = eff[NPINS-1:0];
      clr_v = eff[16 +: NPINS];
    end else if (wr_clr_i) begin
      clr_v = eff[NPINS-1:0];
    end
  end

  assign base_v = wr_odr_i ? ((odr_q & ~wmask_i[NPINS-1:0]) | eff[NPINS-1:0]) : odr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odr_q <= '0;
    else         odr_q <= (base_v & ~clr_v) | set_v;  // set beats clear
  end

  assign odr_o = odr_q;

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr_i |=> ((odr_q & $past(set_v)) == $past(set_v)));

  // R3
  clear_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_setclr_i || wr_clr_i) |=> ((odr_q & $past(clr_v & ~set_v)) == '0));

  // R3
  odr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_odr_i || wr_setclr_i || wr_clr_i) |=> $stable(odr_q));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pin_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*NPINS-1:0]      mode_i,
  input  logic [NPINS-1:0]        otype_i,
  input  logic [2*NPINS-1:0]      pull_i,
  input  logic [AF_SEL_W*NPINS-1:0] afsel_i,
  input  logic [NPINS-1:0]        odr_i,
  input  logic [NPINS-1:0]        pad_in_i,
  input  logic [NAF*NPINS-1:0]    af_out_i,
  output logic [NPINS-1:0]        pad_out_o,
  output logic [NPINS-1:0]        pad_oe_o,
  output logic [NPINS-1:0]        pad_pu_o,
  output logic [NPINS-1:0]        pad_pd_o,
  output logic [NAF*NPINS-1:0]    af_in_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_e           md;
    logic [AF_SEL_W-1:0] sel;
    logic [NAF-1:0]      af_vec, in_vec;
    logic                drive, src;

    assign md     = pin_mode_e'(mode_i[2*p +: 2]);
    assign sel    = afsel_i[AF_SEL_W*p +: AF_SEL_W];
    assign af_vec = af_out_i[NAF*p +: NAF];
    assign drive  = (md == PM_GPOUT) || (md == PM_ALTFN);
    assign src    = (md == PM_ALTFN) ? af_vec[sel] : odr_i[p];

    assign pad_out_o[p] = drive & src;
    assign pad_oe_o[p]  = drive & ~(otype_i[p] & src);  // open-drain releases on high
    assign pad_pu_o[p]  = (md != PM_ANALOG) && (pull_i[2*p +: 2] == 2'b01);
    assign pad_pd_o[p]  = (md != PM_ANALOG) && (pull_i[2*p +: 2] == 2'b10);

    always_comb begin
      in_vec = '0;
      if (md != PM_ANALOG) in_vec[sel] = pad_in_i[p];
    end
    assign af_in_o[NAF*p +: NAF] = in_vec;

    // R9
    od_no_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pad_oe_o[p] && otype_i[p]) |-> !pad_out_o[p]);

    // R12
    quiet_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((md == PM_INPUT) || (md == PM_ANALOG)) |-> !pad_oe_o[p]);

    // R12
    ana_pull_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == PM_ANALOG) |-> !(pad_pu_o[p] || pad_pd_o[p]));

    // R11
    af_in_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(af_in_o[NAF*p +: NAF]));
  end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int          NPINS    = 16,
  parameter int          ADDR_W   = 6,
  parameter logic [31:0] MODE_RST = 32'hFFFF_FFFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [3:0]           be_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NPINS-1:0]     pad_in_i,
  output logic [NPINS-1:0]     pad_out_o,
  output logic [NPINS-1:0]     pad_oe_o,
  output logic [NPINS-1:0]     pad_pu_o,
  output logic [NPINS-1:0]     pad_pd_o,
  output logic [2*NPINS-1:0]   pad_speed_o,
  input  logic [NAF*NPINS-1:0] af_out_i,
  output logic [NAF*NPINS-1:0] af_in_o
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned, wr, rd;
  logic [31:0]       wmask;
  logic [CFG_N-1:0]  cfg_wr;
  logic [31:0]       cfg [CFG_N];
  logic [63:0]       af_all;
  logic [NPINS-1:0]  odr, idr_q, ana_mask;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i & aligned;
  assign wmask   = lane_mask(be_i);

  assign cfg_wr[CFG_MODE]  = wr && (word == WORD_W'(REG_MODE));
  assign cfg_wr[CFG_OTYPE] = wr && (word == WORD_W'(REG_OTYPE));
  assign cfg_wr[CFG_SPEED] = wr && (word == WORD_W'(REG_SPEED));
  assign cfg_wr[CFG_PULL]  = wr && (word == WORD_W'(REG_PULL));
  assign cfg_wr[CFG_AFLO]  = wr && (word == WORD_W'(REG_AFLO));
  assign cfg_wr[CFG_AFHI]  = wr && (word == WORD_W'(REG_AFHI));

  gpio_cfg_regs #(.NPINS(NPINS), .MODE_RST(MODE_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr),
    .wdata_i (wdata_i),
    .wmask_i (wmask),
    .cfg_o   (cfg)
  );

  gpio_out_data #(.NPINS(NPINS)) u_odr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_odr_i    (wr && (word == WORD_W'(REG_ODATA))),
    .wr_setclr_i (wr && (word == WORD_W'(REG_SETCLR))),
    .wr_clr_i    (wr && (word == WORD_W'(REG_CLRONLY))),
    .wdata_i     (wdata_i),
    .wmask_i     (wmask),
    .odr_o       (odr)
  );

  assign af_all = {cfg[CFG_AFHI], cfg[CFG_AFLO]};

  gpio_pin_mux #(.NPINS(NPINS)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (cfg[CFG_MODE][2*NPINS-1:0]),
    .otype_i   (cfg[CFG_OTYPE][NPINS-1:0]),
    .pull_i    (cfg[CFG_PULL][2*NPINS-1:0]),
    .afsel_i   (af_all[AF_SEL_W*NPINS-1:0]),
    .odr_i     (odr),
    .pad_in_i  (pad_in_i),
    .af_out_i  (af_out_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .pad_pu_o  (pad_pu_o),
    .pad_pd_o  (pad_pd_o),
    .af_in_o   (af_in_o)
  );

  assign pad_speed_o = cfg[CFG_SPEED][2*NPINS-1:0];

  for (genvar p = 0; p < NPINS; p++) begin : g_ana
    assign ana_mask[p] = &cfg[CFG_MODE][2*p +: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idr_q <= '0;
    else         idr_q <= pad_in_i & ~ana_mask;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (int'(word))
        REG_MODE:  rdata_o = cfg[CFG_MODE];
        REG_OTYPE: rdata_o = cfg[CFG_OTYPE];
        REG_SPEED: rdata_o = cfg[CFG_SPEED];
        REG_PULL:  rdata_o = cfg[CFG_PULL];
        REG_IDATA: rdata_o = 32'(idr_q);
        REG_ODATA: rdata_o = 32'(odr);
        REG_AFLO:  rdata_o = cfg[CFG_AFLO];
        REG_AFHI:  rdata_o = cfg[CFG_AFHI];
        default:   rdata_o = '0;
      endcase
    end
  end

  // R7
  idr_ana_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ana_mask) |=> ((idr_q & $past(ana_mask)) == '0));

  // R6
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ((word == WORD_W'(REG_SETCLR)) || (word == WORD_W'(REG_CLRONLY)))) |-> (rdata_o == '0));

endmodule

// File: tb/gpio_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb_top;
  import gpio_pin_pkg::*;

  localparam int NP = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          req_i, we_i;
  logic [5:0]    addr_i;
  logic [3:0]    be_i;
  logic [31:0]   wdata_i;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pad_in_i, pad_out_o, pad_oe_o, pad_pu_o, pad_pd_o;
  logic [2*NP-1:0] pad_speed_o;
  logic [NAF*NP-1:0] af_out_i, af_in_o;

  int n_tests = 0;
  int n_fail  = 0;
  string phase = "R1";
  logic [31:0] rng = 32'h1234_5679;

  // behavioural model state
  logic [31:0] m_mode, m_speed, m_pull, m_afl, m_afh;
  logic [15:0] m_otype, m_odr, m_idr;

  always #4 clk_i = ~clk_i;

  gpio_pin_ctrl dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_out_o, .pad_oe_o, .pad_pu_o, .pad_pd_o, .pad_speed_o,
    .af_out_i, .af_in_o
  );

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (int'(a[5:2]))
      0:  return m_mode;
      1:  return {16'h0, m_otype};
      2:  return m_speed;
      3:  return m_pull;
      4:  return {16'h0, m_idr};
      5:  return {16'h0, m_odr};
      8:  return m_afl;
      9:  return m_afh;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 32'hFFFF_FFFF; m_speed = '0; m_pull = '0; m_afl = '0; m_afh = '0;
    m_otype = '0; m_odr = '0; m_idr = '0;
  endtask

  task automatic model_step();
    logic [15:0] nidr;
    logic [31:0] lm, e;
    for (int p = 0; p < NP; p++) nidr[p] = pad_in_i[p] && (m_mode[2*p +: 2] != 2'b11);
    lm = '0;
    for (int b = 0; b < 4; b++) if (be_i[b]) lm[8*b +: 8] = 8'hFF;
    e = wdata_i & lm;
    if (req_i && we_i && addr_i[1:0] == 2'b00) begin
      case (int'(addr_i[5:2]))
        0:  m_mode  = (m_mode & ~lm) | e;
        1:  m_otype = (m_otype & ~lm[15:0]) | e[15:0];
        2:  m_speed = (m_speed & ~lm) | e;
        3:  m_pull  = (m_pull & ~lm) | e;
        5:  m_odr   = (m_odr & ~lm[15:0]) | e[15:0];
        6:  m_odr   = (m_odr & ~e[31:16]) | e[15:0];
        8:  m_afl   = (m_afl & ~lm) | e;
        9:  m_afh   = (m_afh & ~lm) | e;
        10: m_odr   = m_odr & ~e[15:0];
        default: ;
      endcase
    end
    m_idr = nidr;
  endtask

  task automatic chk(input string what, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [15:0] e_out, e_oe, e_pu, e_pd;
    logic [255:0] e_afin;
    logic [31:0] e_rd;
    e_out = '0; e_oe = '0; e_pu = '0; e_pd = '0; e_afin = '0;
    for (int p = 0; p < NP; p++) begin
      logic [1:0] md;
      logic [3:0] sel;
      logic drv, src;
      md  = m_mode[2*p +: 2];
      sel = (p < 8) ? m_afl[4*p +: 4] : m_afh[4*(p-8) +: 4];
      drv = (md == 2'b01) || (md == 2'b10);
      src = (md == 2'b10) ? af_out_i[16*p + int'(sel)] : m_odr[p];
      e_out[p] = drv && src;
      e_oe[p]  = drv && !(m_otype[p] && src);
      e_pu[p]  = (md != 2'b11) && (m_pull[2*p +: 2] == 2'b01);
      e_pd[p]  = (md != 2'b11) && (m_pull[2*p +: 2] == 2'b10);
      if (md != 2'b11) e_afin[16*p + int'(sel)] = pad_in_i[p];
    end
    e_rd = (req_i && !we_i) ? model_read(addr_i) : 32'h0;
    chk("rdata R2 R6", 256'(rdata_o), 256'(e_rd));
    chk("pad_out R8 R10", 256'(pad_out_o), 256'(e_out));
    chk("pad_oe R9 R12", 256'(pad_oe_o), 256'(e_oe));
    chk("pull_up R12", 256'(pad_pu_o), 256'(e_pu));
    chk("pull_down R12", 256'(pad_pd_o), 256'(e_pd));
    chk("speed R13", 256'(pad_speed_o), 256'(m_speed));
    chk("af_in R11", af_in_o, e_afin);
  endtask

  task automatic cycle();
    #1 compare_all();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; be_i = b; wdata_i = d;
    cycle();
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    cycle();
    req_i = 1'b0;
  endtask

  task automatic shuffle_inputs();
    rng = next_rng(rng);
    pad_in_i = rng[15:0];
    for (int k = 0; k < 8; k++) begin
      rng = next_rng(rng);
      af_out_i[32*k +: 32] = rng;
    end
  endtask

  initial begin
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; be_i = '0; wdata_i = '0;
    pad_in_i = '0; af_out_i = '0;
    model_reset();
    @(negedge clk_i); @(negedge clk_i);
    phase = "R1";
    #1 compare_all();
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int a = 0; a <= 40; a += 4) bus_rd(6'(a));

    // analog pins read zero in the input register
    phase = "R7";
    pad_in_i = 16'hA5C3;
    cycle(); bus_rd(6'h10);
    bus_wr(6'h00, 4'hF, 32'h0);
    cycle(); bus_rd(6'h10);
    pad_in_i = 16'h5A3C;
    bus_rd(6'h10); bus_rd(6'h10);

    phase = "R2";
    bus_wr(6'h00, 4'b0010, 32'h5555_5555); bus_rd(6'h00);
    bus_wr(6'h10, 4'hF, 32'hFFFF_FFFF);    bus_rd(6'h10);
    bus_wr(6'h01, 4'hF, 32'hFFFF_FFFF);    bus_rd(6'h00);
    bus_wr(6'h14, 4'hF, 32'hFFFF_1234);    bus_rd(6'h14);
    bus_wr(6'h04, 4'b1100, 32'hFFFF_FFFF); bus_rd(6'h04);
    req_i = 1'b0; addr_i = 6'h14; cycle();

    phase = "R8";
    bus_wr(6'h00, 4'b0011, 32'h0000_5555);
    bus_wr(6'h14, 4'b0001, 32'h0000_00A6); cycle();

    phase = "R3";
    bus_wr(6'h18, 4'hF, 32'h00F0_000F);    bus_rd(6'h14);
    bus_wr(6'h18, 4'hF, 32'h0);            bus_rd(6'h14);
    bus_wr(6'h18, 4'b0100, 32'hFFFF_FFFF); bus_rd(6'h14);
    bus_wr(6'h18, 4'b0011, 32'hFFFF_FF00); bus_rd(6'h14);

    phase = "R4";
    bus_wr(6'h18, 4'hF, 32'h0101_0101);    bus_rd(6'h14);
    bus_wr(6'h18, 4'hF, 32'hFFFF_FFFF);    bus_rd(6'h14);

    phase = "R5";
    bus_wr(6'h28, 4'hF, 32'hFFFF_0003);    bus_rd(6'h14);
    bus_wr(6'h28, 4'b0010, 32'h0000_FF00); bus_rd(6'h14);

    phase = "R6";
    bus_rd(6'h18); bus_rd(6'h28); bus_rd(6'h1C);

    phase = "R9";
    bus_wr(6'h04, 4'hF, 32'h0000_F00F);
    bus_wr(6'h14, 4'hF, 32'h0000_0F35); cycle();
    bus_wr(6'h14, 4'hF, 32'h0000_F0CA); cycle();

    phase = "R10";
    bus_wr(6'h00, 4'b1100, 32'hAAAA_0000);
    bus_wr(6'h24, 4'hF, 32'hFEDC_BA98);
    for (int i = 0; i < 6; i++) begin shuffle_inputs(); cycle(); end
    bus_wr(6'h00, 4'b0011, 32'h0000_AAAA);
    bus_wr(6'h20, 4'hF, 32'h0F1E_2D3C);
    for (int i = 0; i < 6; i++) begin shuffle_inputs(); cycle(); end

    phase = "R11";
    bus_wr(6'h00, 4'hF, 32'h1B1B_1B1B);
    for (int i = 0; i < 6; i++) begin shuffle_inputs(); cycle(); end

    phase = "R12";
    bus_wr(6'h0C, 4'hF, 32'hE4E4_E4E4);
    bus_wr(6'h00, 4'hF, 32'h0000_0000); cycle();
    bus_wr(6'h00, 4'b1000, 32'hFF00_0000); cycle();
    bus_wr(6'h00, 4'hF, 32'h5555_5555); cycle();

    phase = "R13";
    bus_wr(6'h08, 4'hF, 32'h1B1B_1B1B); bus_rd(6'h08);
    bus_wr(6'h08, 4'b0101, 32'h00FF_00FF); bus_rd(6'h08);

    phase = "R2 R3 R10 mixed";
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      rng = next_rng(rng);
      a = {rng[3:0] % 4'd11, 2'b00};
      if (rng[30:28] == 3'd0) a[0] = 1'b1;
      shuffle_inputs();
      rng = next_rng(rng);
      if (rng[0]) bus_wr(a, rng[4:1], next_rng(rng));
      else        bus_rd(a);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule